// File: doc/BRIEF.md
# Comparator Event and Interrupt Controller

This block is the clocked control and status logic that sits beside an analog voltage comparator. The comparator's result arrives asynchronously. The block passes it through a multi-stage synchronizer and shows the synchronized level as a read-only status bit. It watches that level for the kind of transition picked by a two-bit mode field. A matching transition sets a sticky event flag. The block raises an interrupt request while that flag, a local enable and the core's global interrupt enable are all high.

Software programs the block through one control/status register. There is a write strobe with write data, and the read data is always present. The flag is cleared in one of two ways: software writes a one to its bit, or the interrupt controller pulses an acknowledge when it takes the vector. Two further control bits act outside the block. One selects the internal fixed reference, rather than the external pin, as the comparator's positive input. The other forwards the synchronized result to a timer's capture trigger.

Top module: `acmp_ctrl`

## Requirements
- R1: After reset, every bit of `rd_data` is 0, and `irq_req`, `ref_sel` and `cap_trig` are 0. This gives mode 00, interrupt disabled, capture routing off and the external input selected.
- R2: Register layout (REG_W=8): bit 0 reference select, bit 1 capture enable, bit 2 interrupt enable, bits 4:3 mode, bit 5 event flag, bit 6 synchronized comparator level (read-only), bit 7 reads 0. With SYNC_STAGES=2, bit 6 takes a new `cmp_raw` level on the second rising clock edge after the change. A matching event sets the flag one edge after that.
- R3: Mode 00 sets the flag on every change of the synchronized level, rising or falling.
- R4: Mode 10 sets the flag only on a falling transition. Mode 11 sets it only on a rising transition.
- R5: Mode 01 is reserved and never sets the flag.
- R6: Once set, the flag stays at 1 until it is cleared.
- R7: Writing a 1 to bit 5 clears the flag. A write with bit 5 at 0 leaves the flag unchanged.
- R8: A one-cycle pulse on `irq_ack` clears the flag.
- R9: `irq_req` is 1 exactly when the flag, bit 2 and `gie` are all 1.
- R10: While bit 1 is 1, `cap_trig` follows the synchronized level. While bit 1 is 0, `cap_trig` is 0.
- R11: `ref_sel` equals bit 0 of the register.
- R12: An event in the same cycle as a write-one clear or an acknowledge leaves the flag set.
- R13: If `cmp_raw` is already high when reset is released, no event is recorded. The flag stays 0 while bit 6 settles to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Unsynchronized comparator result |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read data |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Vector acknowledge, clears the flag |
| irq_req | output | 1 | Interrupt request |
| ref_sel | output | 1 | Positive-input mux select, 1 = internal reference |
| cap_trig | output | 1 | Trigger to the timer capture front end |

## Verification
A stale previous-level register or a miscoded mode shows up at bit 5 of `rd_data` exactly three edges after a `cmp_raw` change: the flag is either missing or set when it should not be. The same fault reaches `irq_req` in that same cycle once the interrupt is enabled. A synchronizer of the wrong depth moves bit 6 and `cap_trig` by a whole cycle, so both are sampled on the edge before and the edge of the expected change. Wrong clear priority can only be seen in collision cycles, which is why the bench lines up a write or an acknowledge exactly with the event cycle.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

   typedef enum logic [1:0] {
      EV_TOGGLE = 2'b00,
      EV_RSVD   = 2'b01,
      EV_FALL   = 2'b10,
      EV_RISE   = 2'b11
   } ev_mode_e;

   // register field positions
   localparam int unsigned BIT_REF     = 0;
   localparam int unsigned BIT_CAP     = 1;
   localparam int unsigned BIT_IE      = 2;
   localparam int unsigned BIT_MODE_LO = 3;
   localparam int unsigned BIT_MODE_HI = 4;
   localparam int unsigned BIT_FLAG    = 5;
   localparam int unsigned BIT_OUT     = 6;
   localparam int unsigned MIN_REG_W   = BIT_OUT + 1;

   typedef struct packed {
      ev_mode_e mode;
      logic     ie;
      logic     cap;
      logic     ref_int;
   } ctrl_t;

endpackage

// File: rtl/acmp_sync.sv
module acmp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/acmp_edge.sv
module acmp_edge
   import acmp_pkg::*;
#(
   parameter int unsigned SETTLE = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sync_i,
   input  ev_mode_e mode_i,
   output logic     event_o
);

   localparam int unsigned CW = $clog2(SETTLE + 1);
   localparam logic [CW-1:0] SETTLE_END = SETTLE[CW-1:0];

   logic [CW-1:0] settle_q;
   logic          prev_q;
   logic          armed;
   logic          rise, fall, hit;

   assign armed = (settle_q == SETTLE_END);

   // the previous level tracks the synchronizer every cycle; events stay
   // masked until the chain and the previous level both hold post-reset data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_q <= '0;
         prev_q   <= 1'b0;
      end else begin
         prev_q <= sync_i;
         if (!armed) settle_q <= settle_q + 1'b1;
      end
   end

   assign rise = sync_i & ~prev_q;
   assign fall = ~sync_i & prev_q;

   always_comb begin
      unique case (mode_i)
         EV_TOGGLE: hit = rise | fall;
         EV_FALL:   hit = fall;
         EV_RISE:   hit = rise;
         default:   hit = 1'b0;
      endcase
   end

   assign event_o = armed & hit;

endmodule

// File: rtl/acmp_regs.sv
module acmp_regs
   import acmp_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ack_i,
   input  logic             event_i,
   input  logic             sync_i,
   output ctrl_t            ctrl_o,
   output logic             flag_o,
   output logic [REG_W-1:0] rd_data_o
);

   ctrl_t ctrl_q;
   logic  flag_q;
   logic  clr;
   logic  unused_wr_bits;

   assign unused_wr_bits = ^wr_data[REG_W-1:BIT_OUT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{mode: EV_TOGGLE, ie: 1'b0, cap: 1'b0, ref_int: 1'b0};
      end else if (wr_en) begin
         ctrl_q.ref_int <= wr_data[BIT_REF];
         ctrl_q.cap     <= wr_data[BIT_CAP];
         ctrl_q.ie      <= wr_data[BIT_IE];
         ctrl_q.mode    <= ev_mode_e'(wr_data[BIT_MODE_HI:BIT_MODE_LO]);
      end
   end

   assign clr = ack_i | (wr_en & wr_data[BIT_FLAG]);

   // a new event outranks both clear sources
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (event_i) flag_q <= 1'b1;
      else if (clr)     flag_q <= 1'b0;
   end

   always_comb begin
      rd_data_o                          = '0;
      rd_data_o[BIT_REF]                 = ctrl_q.ref_int;
      rd_data_o[BIT_CAP]                 = ctrl_q.cap;
      rd_data_o[BIT_IE]                  = ctrl_q.ie;
      rd_data_o[BIT_MODE_HI:BIT_MODE_LO] = ctrl_q.mode;
      rd_data_o[BIT_FLAG]                = flag_q;
      rd_data_o[BIT_OUT]                 = sync_i;
   end

   assign ctrl_o = ctrl_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/acmp_ctrl.sv
module acmp_ctrl
   import acmp_pkg::*;
#(
   parameter int unsigned REG_W         = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          CAPTURE_ROUTE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_raw,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             gie,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic             ref_sel,
   output logic             cap_trig
);

   localparam int unsigned SETTLE = SYNC_STAGES + 1;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("acmp_ctrl: REG_W too small for the register layout");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("acmp_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic  cmp_sync;
   logic  ev;
   logic  flag;
   ctrl_t ctrl;

   acmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cmp_raw),
      .sync_o  (cmp_sync)
   );

   acmp_edge #(.SETTLE(SETTLE)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (cmp_sync),
      .mode_i  (ctrl.mode),
      .event_o (ev)
   );

   acmp_regs #(.REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .ack_i     (irq_ack),
      .event_i   (ev),
      .sync_i    (cmp_sync),
      .ctrl_o    (ctrl),
      .flag_o    (flag),
      .rd_data_o (rd_data)
   );

   assign irq_req = flag & ctrl.ie & gie;
   assign ref_sel = ctrl.ref_int;

   generate
      if (CAPTURE_ROUTE) begin : g_cap
         assign cap_trig = ctrl.cap & cmp_sync;
      end else begin : g_nocap
         assign cap_trig = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/acmp_chk.sv
module acmp_chk
   import acmp_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             gie,
   input logic             irq_ack,
   input logic             irq_req,
   input logic             ref_sel,
   input logic             cap_trig
);

   // R5
   rsv_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[BIT_MODE_HI:BIT_MODE_LO] == 2'b01 && !rd_data[BIT_FLAG]) |=> !rd_data[BIT_FLAG]);

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_FLAG] && rd_data[BIT_MODE_HI:BIT_MODE_LO] == 2'b01) |=> !rd_data[BIT_FLAG]);

   // R7
   w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[BIT_FLAG] && !irq_ack && rd_data[BIT_FLAG]) |=> rd_data[BIT_FLAG]);

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && rd_data[BIT_MODE_HI:BIT_MODE_LO] == 2'b01) |=> !rd_data[BIT_FLAG]);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (rd_data[BIT_FLAG] && rd_data[BIT_IE] && gie));

   // R10
   cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[BIT_CAP] |-> !cap_trig);

   // R11
   ref_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_sel == rd_data[BIT_REF]);

   // R4
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_data[BIT_FLAG]) && $past(rd_data[BIT_MODE_HI:BIT_MODE_LO]) == 2'b11)
      |-> ($past(rd_data[BIT_OUT]) && !$past(rd_data[BIT_OUT], 2)));

endmodule

bind acmp_ctrl acmp_chk #(.REG_W(REG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .gie      (gie),
   .irq_ack  (irq_ack),
   .irq_req  (irq_req),
   .ref_sel  (ref_sel),
   .cap_trig (cap_trig)
);

// File: tb/tb_acmp_ctrl.sv
module tb_acmp_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       gie = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq_req;
   logic       ref_sel;
   logic       cap_trig;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   acmp_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .gie(gie), .irq_ack(irq_ack),
      .irq_req(irq_req), .ref_sel(ref_sel), .cap_trig(cap_trig)
   );

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cw(input logic rsel, input logic cap, input logic ie,
                                     input logic [1:0] mode, input logic clr);
      return {2'b00, clr, mode, ie, cap, rsel};
   endfunction

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      step(1);
      wr_en = 1'b0;
      wr_data = 8'h00;
   endtask

   function automatic logic flag();
      return rd_data[5];
   endfunction

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 0);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 ref_sel", ref_sel, 0);
      chk("R1 cap_trig", cap_trig, 0);
   endtask

   task automatic t_sync_toggle();
      cmp_raw = 1'b1;
      step(1);
      chk("R2 out after 1 edge", rd_data[6], 0);
      step(1);
      chk("R2 out after 2 edges", rd_data[6], 1);
      chk("R2 flag not yet", flag(), 0);
      step(1);
      chk("R3 toggle rise sets", flag(), 1);
      wr(cw(0, 0, 0, 2'b00, 1));
      chk("R7 w1c", flag(), 0);
      cmp_raw = 1'b0;
      step(3);
      chk("R3 toggle fall sets", flag(), 1);
      wr(cw(0, 0, 0, 2'b00, 1));
   endtask

   task automatic t_fall();
      wr(cw(0, 0, 0, 2'b10, 1));
      cmp_raw = 1'b1;
      step(3);
      chk("R4 fall mode ignores rise", flag(), 0);
      cmp_raw = 1'b0;
      step(3);
      chk("R4 fall mode sets", flag(), 1);
      wr(cw(0, 0, 0, 2'b10, 1));
   endtask

   task automatic t_rise();
      wr(cw(0, 0, 0, 2'b11, 1));
      cmp_raw = 1'b1;
      step(3);
      chk("R4 rise mode sets", flag(), 1);
      wr(cw(0, 0, 0, 2'b11, 1));
      cmp_raw = 1'b0;
      step(3);
      chk("R4 rise mode ignores fall", flag(), 0);
   endtask

   task automatic t_reserved();
      wr(cw(0, 0, 0, 2'b01, 1));
      cmp_raw = 1'b1;
      step(3);
      chk("R5 reserved rise", flag(), 0);
      cmp_raw = 1'b0;
      step(3);
      chk("R5 reserved fall", flag(), 0);
   endtask

   task automatic t_sticky_w0();
      wr(cw(0, 0, 0, 2'b00, 1));
      cmp_raw = 1'b1;
      step(3);
      chk("R6 set", flag(), 1);
      step(5);
      chk("R6 sticky", flag(), 1);
      wr(cw(0, 0, 0, 2'b00, 0));
      chk("R7 write zero keeps", flag(), 1);
      wr(cw(0, 0, 0, 2'b00, 1));
      chk("R7 write one clears", flag(), 0);
   endtask

   task automatic t_ack();
      cmp_raw = 1'b0;
      step(3);
      chk("R8 set before ack", flag(), 1);
      irq_ack = 1'b1;
      step(1);
      irq_ack = 1'b0;
      chk("R8 ack clears", flag(), 0);
   endtask

   task automatic t_irq();
      wr(cw(0, 0, 1, 2'b00, 0));
      cmp_raw = 1'b1;
      step(3);
      chk("R9 flag set", flag(), 1);
      chk("R9 gie low masks", irq_req, 0);
      gie = 1'b1;
      #1;
      chk("R9 all set", irq_req, 1);
      wr(cw(0, 0, 0, 2'b00, 0));
      chk("R9 ie low masks", irq_req, 0);
      wr(cw(0, 0, 1, 2'b00, 1));
      chk("R9 flag clear masks", irq_req, 0);
      gie = 1'b0;
   endtask

   task automatic t_priority();
      wr(cw(0, 0, 0, 2'b00, 1));
      cmp_raw = 1'b0;
      step(3);
      cmp_raw = 1'b1;
      step(2);
      wr(cw(0, 0, 0, 2'b00, 1));
      chk("R12 event beats w1c", flag(), 1);
      cmp_raw = 1'b0;
      step(2);
      irq_ack = 1'b1;
      step(1);
      irq_ack = 1'b0;
      chk("R12 event beats ack", flag(), 1);
      wr(cw(0, 0, 0, 2'b00, 1));
      chk("R12 later clear works", flag(), 0);
   endtask

   task automatic t_capture();
      cmp_raw = 1'b1;
      step(2);
      chk("R10 off holds low", cap_trig, 0);
      wr(cw(0, 1, 0, 2'b01, 1));
      chk("R10 on follows high", cap_trig, 1);
      cmp_raw = 1'b0;
      step(2);
      chk("R10 on follows low", cap_trig, 0);
      cmp_raw = 1'b1;
      step(1);
      chk("R10 sync delay", cap_trig, 0);
      step(1);
      chk("R10 follows after sync", cap_trig, 1);
      wr(cw(0, 0, 0, 2'b01, 1));
      chk("R10 disabled again", cap_trig, 0);
   endtask

   task automatic t_ref();
      wr(cw(1, 0, 0, 2'b01, 1));
      chk("R11 ref_sel high", ref_sel, 1);
      chk("R11 read bit", rd_data[0], 1);
      wr(cw(0, 0, 0, 2'b01, 1));
      chk("R11 ref_sel low", ref_sel, 0);
   endtask

   task automatic t_reset_high();
      cmp_raw = 1'b1;
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(6);
      chk("R13 no event from reset", flag(), 0);
      chk("R13 out settled", rd_data[6], 1);
      cmp_raw = 1'b0;
      step(3);
      chk("R13 later event seen", flag(), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(5);
      t_reset();
      t_sync_toggle();
      t_fall();
      t_rise();
      t_reserved();
      t_sticky_w0();
      t_ack();
      t_irq();
      t_priority();
      t_capture();
      t_ref();
      t_reset_high();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule